// File: doc/BRIEF.md
# Mask-Based Data-Reversal Barrel Shifter

A purely combinational shifter that performs six shift and rotate operations on a parameterised operand (32 bits by default) with a shift amount of log2 of that width. A single right rotator does all the data movement: for left-direction operations the operand is bit-reversed before the rotator and the rotator output is bit-reversed again afterwards. Vacated positions are not produced by separate shifters. A thermometer mask derived from the shift amount decides, bit by bit, whether the rotator output is kept or replaced by a fill bit.

Two status flags leave the block with the result. The overflow flag reports that an arithmetic left shift lost significance. The zero flag reports an all-zero result. Neither flag is derived from the result. Both are formed from the operand and the mask, side by side with the rotator, so they add no depth behind it.

Opcode bit 2 selects the direction (0 right, 1 left). Opcode bits 1:0 select the kind of operation: 00 logical, 01 arithmetic, 1x rotate.

Top module: `mdr_barrel_shifter`

## Requirements
- R1: Opcode 000 (logical right) gives the operand shifted right by the amount, with zeros entering at bit W-1.
- R2: Opcode 001 (arithmetic right) gives the operand shifted right by the amount, with copies of operand bit W-1 entering at the top.
- R3: Opcode 010 rotates the operand right by the amount and opcode 110 rotates it left by the amount; no bit is lost.
- R4: Opcodes 100 (logical left) and 101 (arithmetic left) both give the operand shifted left by the amount, with zeros entering at bit 0.
- R5: The overflow output is driven only by opcode 101. It is set when any operand bit from position W-1-amount up to W-1 differs from operand bit W-1. For every other opcode it is 0.
- R6: The zero output is 1 exactly when all W result bits are 0, for every opcode.
- R7: An amount of 0 returns the operand unchanged with overflow 0, for every opcode.
- R8: Opcode 011 behaves as rotate right and opcode 111 behaves as rotate left, because bit 1 set selects rotation whatever bit 0 is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | DATA_W | Data to shift or rotate |
| amount_i | input | log2(DATA_W) | Shift or rotate distance |
| opcode_i | input | 3 | Bit 2 is the direction (1 = left); bits 1:0 are the kind (00 logical, 01 arithmetic, 1x rotate) |
| result_o | output | DATA_W | Shifted or rotated data |
| overflow_o | output | 1 | Arithmetic left shift lost significance |
| zero_o | output | 1 | Result is all zeros |

## Verification
Overflow and zero are built from the same mask in parallel with the rotator, so both can be set for one operand. An arithmetic left shift of a top-bit-only operand clears every kept bit and also changes the sign, which sets both flags together. The bench provokes this by sweeping every opcode and every amount over edge operands (top bit only, all ones, alternating bits, single low bit) as well as random ones. It judges the result and both flags of each case against shift-operator arithmetic. For the overflow flag, that arithmetic shifts the value back and compares it with the operand.

// File: rtl/mdr_bshift_pkg.sv
package mdr_bshift_pkg;

   typedef enum logic [2:0] {
      OP_SRL = 3'b000,
      OP_SRA = 3'b001,
      OP_ROR = 3'b010,
      OP_SLL = 3'b100,
      OP_SLA = 3'b101,
      OP_ROL = 3'b110
   } shift_op_e;

   typedef struct packed {
      logic left;
      logic rotate;
      logic arith;
   } shift_ctl_t;

   // bit 2 = direction, bit 1 = rotate, bit 0 = arithmetic (only when not rotating)
   function automatic shift_ctl_t decode_op(input logic [2:0] op);
      shift_ctl_t c;
      c.left   = op[2];
      c.rotate = op[1];
      c.arith  = ~op[1] & op[0];
      return c;
   endfunction

endpackage

// File: rtl/bshift_reverse.sv
module bshift_reverse #(
   parameter int W = 32
) (
   input  logic         rev_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout_o[i] = rev_i ? din_i[W-1-i] : din_i[i];
   end
endmodule

// File: rtl/bshift_rotr.sv
module bshift_rotr #(
   parameter int W     = 32,
   parameter int STYLE = 0,
   localparam int SW   = $clog2(W)
) (
   input  logic [W-1:0]  din_i,
   input  logic [SW-1:0] amt_i,
   output logic [W-1:0]  dout_o
);
   if (STYLE == 0) begin : g_log
      // one 2:1 mux level per amount bit
      logic [W-1:0] stg [0:SW];
      assign stg[0] = din_i;
      for (genvar k = 0; k < SW; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stg[k+1] = amt_i[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
      end
      assign dout_o = stg[SW];
   end else begin : g_dbl
      // double-width funnel: low half of the shifted pair is the rotation
      logic [2*W-1:0] dbl;
      assign dbl    = {din_i, din_i} >> amt_i;
      assign dout_o = dbl[W-1:0];
   end
endmodule

// File: rtl/bshift_mask.sv
module bshift_mask #(
   parameter int W     = 32,
   parameter int STYLE = 0,
   localparam int SW   = $clog2(W)
) (
   input  logic [SW-1:0] amt_i,
   output logic [W-1:0]  keep_o
);
   // keep_o[i] = 1 when result bit i (right-shift frame) comes from the rotator
   if (STYLE == 0) begin : g_cmp
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam logic [SW-1:0] LIM = SW'(W - 1 - i);
         assign keep_o[i] = (amt_i <= LIM);
      end
   end else begin : g_thermo
      assign keep_o = {W{1'b1}} >> amt_i;
   end
endmodule

// File: rtl/bshift_flags.sv
module bshift_flags #(
   parameter int W = 32
) (
   input  logic [W-1:0] frame_i,      // operand in the rotator frame
   input  logic [W-1:0] keep_frame_i, // mask mapped onto operand positions of the frame
   input  logic [W-1:0] operand_i,    // operand in its own order
   input  logic [W-1:0] keep_raw_i,   // amount-only mask, before rotate override
   input  logic         sla_i,
   input  logic         fill_i,
   output logic         ovf_o,
   output logic         zero_o
);
   logic [W-1:0] differs;
   logic [W-1:0] window;

   // window covers positions W-1-amt .. W-1: bits shifted out plus the new sign
   assign differs = operand_i ^ {W{operand_i[W-1]}};
   assign window  = ~keep_raw_i >> 1;
   assign ovf_o   = sla_i & (|(differs & window));

   // a set fill bit implies a set operand sign, which is kept at amount 0
   assign zero_o  = ~(|(frame_i & keep_frame_i)) & ~fill_i;
endmodule

// File: rtl/mdr_barrel_shifter.sv
module mdr_barrel_shifter #(
   parameter int DATA_W     = 32,
   parameter int MASK_STYLE = 0,
   parameter int ROT_STYLE  = 0,
   localparam int AMT_W     = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] operand_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  logic [2:0]        opcode_i,
   output logic [DATA_W-1:0] result_o,
   output logic              overflow_o,
   output logic              zero_o
);
   import mdr_bshift_pkg::*;

   initial begin
      if (DATA_W < 2 || (1 << AMT_W) != DATA_W)
         $error("DATA_W must be a power of two of at least 2");
      if (MASK_STYLE < 0 || MASK_STYLE > 1)
         $error("MASK_STYLE must be 0 or 1");
      if (ROT_STYLE < 0 || ROT_STYLE > 1)
         $error("ROT_STYLE must be 0 or 1");
   end

   shift_ctl_t          ctl;
   logic [DATA_W-1:0]   frame;
   logic [DATA_W-1:0]   rotated;
   logic [DATA_W-1:0]   keep_raw;
   logic [DATA_W-1:0]   keep_eff;
   logic [DATA_W-1:0]   keep_frame;
   logic [DATA_W-1:0]   merged;
   logic                fill;
   logic                sla;

   assign ctl  = decode_op(opcode_i);
   assign fill = ~ctl.left & ctl.arith & operand_i[DATA_W-1];
   assign sla  = ctl.left & ctl.arith;

   bshift_reverse #(.W(DATA_W)) u_rev_in (
      .rev_i  (ctl.left),
      .din_i  (operand_i),
      .dout_o (frame)
   );

   bshift_rotr #(.W(DATA_W), .STYLE(ROT_STYLE)) u_rot (
      .din_i  (frame),
      .amt_i  (amount_i),
      .dout_o (rotated)
   );

   bshift_mask #(.W(DATA_W), .STYLE(MASK_STYLE)) u_mask (
      .amt_i  (amount_i),
      .keep_o (keep_raw)
   );

   assign keep_eff = ctl.rotate ? {DATA_W{1'b1}} : keep_raw;

   // kept result bit i comes from frame bit i+amt: the reversed mask marks those
   bshift_reverse #(.W(DATA_W)) u_rev_mask (
      .rev_i  (1'b1),
      .din_i  (keep_eff),
      .dout_o (keep_frame)
   );

   assign merged = (rotated & keep_eff) | ({DATA_W{fill}} & ~keep_eff);

   bshift_reverse #(.W(DATA_W)) u_rev_out (
      .rev_i  (ctl.left),
      .din_i  (merged),
      .dout_o (result_o)
   );

   bshift_flags #(.W(DATA_W)) u_flags (
      .frame_i      (frame),
      .keep_frame_i (keep_frame),
      .operand_i    (operand_i),
      .keep_raw_i   (keep_raw),
      .sla_i        (sla),
      .fill_i       (fill),
      .ovf_o        (overflow_o),
      .zero_o       (zero_o)
   );
endmodule

// File: rtl/mdr_barrel_shifter_chk.sv
module mdr_barrel_shifter_chk #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input logic [DATA_W-1:0] operand_i,
   input logic [AMT_W-1:0]  amount_i,
   input logic [2:0]        opcode_i,
   input logic [DATA_W-1:0] result_o,
   input logic              overflow_o,
   input logic              zero_o
);
   import mdr_bshift_pkg::*;

   always_comb begin
      if (opcode_i == OP_SRL && amount_i != '0)
         p_srl_top_clear_r1: assert (result_o[DATA_W-1] == 1'b0)
            else $error("R1 logical right left a set top bit");
      if (opcode_i == OP_SRA)
         p_sra_sign_kept_r2: assert (result_o[DATA_W-1] == operand_i[DATA_W-1])
            else $error("R2 arithmetic right changed the sign");
      if (opcode_i[1])
         p_rotate_popcount_r3: assert ($countones(result_o) == $countones(operand_i))
            else $error("R3 rotate changed the number of set bits");
      if (opcode_i[2] && !opcode_i[1] && amount_i != '0)
         p_left_low_clear_r4: assert (result_o[0] == 1'b0)
            else $error("R4 left shift left a set bit 0");
      if (opcode_i != OP_SLA)
         p_no_overflow_r5: assert (!overflow_o)
            else $error("R5 overflow outside arithmetic left");
      p_zero_flag_r6: assert (zero_o == (result_o == '0))
         else $error("R6 zero flag disagrees with result");
      if (amount_i == '0)
         p_identity_r7: assert (result_o == operand_i && !overflow_o)
            else $error("R7 zero amount altered the operand");
   end
endmodule

bind mdr_barrel_shifter mdr_barrel_shifter_chk #(.DATA_W(DATA_W)) u_chk (
   .operand_i  (operand_i),
   .amount_i   (amount_i),
   .opcode_i   (opcode_i),
   .result_o   (result_o),
   .overflow_o (overflow_o),
   .zero_o     (zero_o)
);

// File: tb/mdr_barrel_shifter_tb.sv
module mdr_barrel_shifter_tb;
   localparam int W   = 32;
   localparam int SW  = 5;
   localparam int NPAT = 44;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  operand;
   logic [SW-1:0] amount;
   logic [2:0]    opcode;
   logic [W-1:0]  result;
   logic          overflow;
   logic          zero;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   mdr_barrel_shifter #(.DATA_W(W)) u_dut (
      .operand_i  (operand),
      .amount_i   (amount),
      .opcode_i   (opcode),
      .result_o   (result),
      .overflow_o (overflow),
      .zero_o     (zero)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000 && !done) begin
         n_fails++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   function automatic logic [W-1:0] ref_result(input int op, input int s, input logic [W-1:0] a);
      case (op)
         0:       return a >> s;
         1:       return W'($signed(a) >>> s);
         2, 3:    return (a >> s) | (a << (W - s));
         4, 5:    return a << s;
         default: return (a << s) | (a >> (W - s));
      endcase
   endfunction

   function automatic logic ref_ovf(input int op, input int s, input logic [W-1:0] a);
      logic [W-1:0] back;
      if (op != 5) return 1'b0;
      back = W'($signed(a << s) >>> s);
      return back != a;
   endfunction

   function automatic string res_tag(input int op, input int s);
      if (s == 0) return "R7";
      case (op)
         0: return "R1";
         1: return "R2";
         2, 6: return "R3";
         3, 7: return "R8";
         default: return "R4";
      endcase
   endfunction

   function automatic logic [W-1:0] pattern(input int k);
      case (k)
         0: return '0;
         1: return '1;
         2: return 32'h8000_0000;
         3: return 32'h0000_0001;
         4: return 32'h7FFF_FFFF;
         5: return 32'hAAAA_AAAA;
         6: return 32'h5555_5555;
         7: return 32'hC000_0000;
         8: return 32'h4000_0000;
         9: return 32'hFFFF_0000;
         default: return $urandom();
      endcase
   endfunction

   task automatic apply_and_check(input int op, input int s, input logic [W-1:0] a);
      logic [W-1:0] exp_r;
      logic         exp_o;
      logic         exp_z;
      @(posedge clk);
      operand = a;
      amount  = SW'(s);
      opcode  = 3'(op);
      @(negedge clk);
      exp_r = ref_result(op, s, a);
      exp_o = ref_ovf(op, s, a);
      exp_z = (exp_r == '0);
      n_checks++;
      if (result !== exp_r) begin
         n_fails++;
         $display("FAIL %s result op=%0d amt=%0d a=%h actual=%h expected=%h",
                  res_tag(op, s), op, s, a, result, exp_r);
      end
      n_checks++;
      if (overflow !== exp_o) begin
         n_fails++;
         $display("FAIL %s overflow op=%0d amt=%0d a=%h actual=%0b expected=%0b",
                  (s == 0) ? "R7" : "R5", op, s, a, overflow, exp_o);
      end
      n_checks++;
      if (zero !== exp_z) begin
         n_fails++;
         $display("FAIL R6 zero op=%0d amt=%0d a=%h actual=%0b expected=%0b",
                  op, s, a, zero, exp_z);
      end
   endtask

   initial begin
      operand = '0;
      amount  = '0;
      opcode  = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // idle state: zero operand gives zero result, zero flag, no overflow (R6)
      n_checks++;
      if (result !== '0 || zero !== 1'b1 || overflow !== 1'b0) begin
         n_fails++;
         $display("FAIL R6 idle actual=%h/%0b/%0b expected=0/1/0", result, zero, overflow);
      end
      // corner: SLA of top-bit-only by 1 sets overflow and zero together (R5, R6)
      apply_and_check(5, 1, 32'h8000_0000);
      // R3 R8 every opcode, every amount, edge and random operands
      for (int op = 0; op < 8; op++)
         for (int s = 0; s < W; s++)
            for (int k = 0; k < NPAT; k++)
               apply_and_check(op, s, pattern(k));
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule